// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands and writes the outcome into a two-bit condition field of a floating-point status register. A precision input selects whether the operands are read as 64-bit values or as 32-bit values taken from the low halves of the operand buses. The comparison uses sign-magnitude ordering, treats the two zeros as equal and reports any NaN operand as unordered.

An unordered result is handled through two bits of the same status register. If the invalid trap-enable bit is set, the block raises a one-cycle trap request and a fixed trap-type code. If that bit is clear, the block sets a sticky accrued-invalid flag and does not trap. No other status bit is touched by a compare. Software loads and reads the whole register through a plain write strobe and a read bus. A compare is started by a one-cycle strobe. The new condition field and any trap request appear one clock later, together with a done pulse.

Top module: `fp_cmp_cc`

## Requirements
- R1: After reset the status register reads 0 and done, trap and trap_type are all 0.
- R2: A start strobe in one cycle produces a done pulse in the next cycle, with the updated register already visible on sr_rd_data. Without a start strobe, done stays 0.
- R3: If either operand is a NaN, the condition field (sr bits 11:10) becomes 3. A NaN has an all-ones exponent and a nonzero fraction, whatever its sign. An infinity is not a NaN.
- R4: For ordered operands, the condition field becomes 1 when operand A is below operand B, 2 when A is above B, and 0 when they are equal.
- R5: +0 and -0 compare equal in either order and at either precision.
- R6: Ordering follows the sign: any negative value is below any positive value, among negatives the larger magnitude is lower, and infinities order beyond every finite value.
- R7: On an unordered result with the trap-enable bit (sr bit 27) set, trap pulses for one cycle with trap_type 0x08, and the accrued-invalid bit (sr bit 5) keeps its value.
- R8: On an unordered result with sr bit 27 clear, sr bit 5 is set and trap stays 0. An ordered compare never clears sr bit 5.
- R9: With dbl=1 the operands are the full 64-bit values (exponent 11 bits, fraction 52 bits). With dbl=0 only bits 31:0 are used (exponent 8 bits, fraction 23 bits), and bits 63:32 have no effect.
- R10: A compare changes only sr bits 11:10 and sr bit 5. A register write loads all 32 bits. When a write and a start fall in the same cycle, the written value is the base and the compare result is laid over it. The trap decision uses bit 27 as it was held before that edge.
- R11: trap_type is 0 in every cycle where trap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle compare request |
| dbl | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands in bits 31:0 |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| sr_wr_en | input | 1 | Status register write strobe |
| sr_wr_data | input | 32 | Status register write value |
| sr_rd_data | output | 32 | Current status register value |
| done | output | 1 | Result-valid pulse, one cycle after start |
| trap | output | 1 | Floating-point exception trap request |
| trap_type | output | 8 | Trap-type code, nonzero only with trap |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle timing from start to done;
- that a trap occurs only with an unordered condition field and leaves the accrued bit alone;
- that an untrapped unordered result always shows the accrued bit set;
- that a compare leaves every bit outside the condition field and the accrued bit unchanged;
- that the register holds while idle.

Whether the ordering itself is correct can be shown only by the bench's operand scenarios. These cover signed zeros, negative values, infinities, subnormals, NaNs of either sign, and junk in the unused upper half of single-precision operands. The bench scenarios also cover the overlay of a simultaneous write and compare.

// File: rtl/fp_cmp_cc.sv
module fp_cmp_cc #(
  parameter int SR_W     = 32,
  parameter int FCC_LO   = 10,
  parameter int NV_ACC   = 5,
  parameter int NV_MASK  = 27,
  parameter int TT_W     = 8,
  parameter logic [7:0] TT_FPEXC = 8'h08
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dbl,
  input  logic [63:0]     op_a,
  input  logic [63:0]     op_b,
  input  logic            sr_wr_en,
  input  logic [SR_W-1:0] sr_wr_data,
  output logic [SR_W-1:0] sr_rd_data,
  output logic            done,
  output logic            trap,
  output logic [TT_W-1:0] trap_type
);

  localparam int D_W    = 64;
  localparam int D_EXP  = 11;
  localparam int D_FRAC = D_W - 1 - D_EXP;
  localparam int S_W    = 32;
  localparam int S_EXP  = 8;
  localparam int S_FRAC = S_W - 1 - S_EXP;
  localparam int MAG_W  = D_W - 1;

  localparam logic [SR_W-1:0] TOUCHED =
    (SR_W'(3) << FCC_LO) | (SR_W'(1) << NV_ACC);
  localparam logic [SR_W-1:0] KEEP = ~TOUCHED;

  logic [SR_W-1:0] sr_q, sr_d;
  logic            done_q, trap_q;

  logic             sgn_a, sgn_b, nan_a, nan_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             unord, a_lt, a_gt;
  logic [1:0]       code;

  function automatic logic is_nan_d(input logic [D_W-1:0] v);
    return (&v[D_W-2 -: D_EXP]) && (|v[D_FRAC-1:0]);
  endfunction

  function automatic logic is_nan_s(input logic [S_W-1:0] v);
    return (&v[S_W-2 -: S_EXP]) && (|v[S_FRAC-1:0]);
  endfunction

  assign sgn_a = dbl ? op_a[D_W-1] : op_a[S_W-1];
  assign sgn_b = dbl ? op_b[D_W-1] : op_b[S_W-1];
  assign nan_a = dbl ? is_nan_d(op_a) : is_nan_s(op_a[S_W-1:0]);
  assign nan_b = dbl ? is_nan_d(op_b) : is_nan_s(op_b[S_W-1:0]);
  assign mag_a = dbl ? op_a[D_W-2:0] : MAG_W'(op_a[S_W-2:0]);
  assign mag_b = dbl ? op_b[D_W-2:0] : MAG_W'(op_b[S_W-2:0]);

  assign unord = nan_a | nan_b;

  always_comb begin
    a_lt = 1'b0;
    a_gt = 1'b0;
    if (mag_a == '0 && mag_b == '0) begin
      a_lt = 1'b0;
      a_gt = 1'b0;
    end else if (sgn_a != sgn_b) begin
      a_lt = sgn_a;
      a_gt = sgn_b;
    end else if (!sgn_a) begin
      a_lt = mag_a < mag_b;
      a_gt = mag_a > mag_b;
    end else begin
      a_lt = mag_a > mag_b;
      a_gt = mag_a < mag_b;
    end
  end

  assign code = unord ? 2'd3 : a_lt ? 2'd1 : a_gt ? 2'd2 : 2'd0;

  always_comb begin
    sr_d = sr_wr_en ? sr_wr_data : sr_q;
    if (start) begin
      sr_d[FCC_LO +: 2] = code;
      if (unord && !sr_q[NV_MASK]) sr_d[NV_ACC] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      done_q <= start;
      trap_q <= start & unord & sr_q[NV_MASK];
    end
  end

  assign sr_rd_data = sr_q;
  assign done       = done_q;
  assign trap       = trap_q;
  assign trap_type  = trap_q ? TT_W'(TT_FPEXC) : '0;

  assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  assert_trap_unordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (done && sr_rd_data[FCC_LO +: 2] == 2'd3));

  assert_trap_keeps_accrued_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sr_wr_en) |=> (!trap || sr_rd_data[NV_ACC] == $past(sr_rd_data[NV_ACC])));

  assert_untrapped_accrues_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trap && sr_rd_data[FCC_LO +: 2] == 2'd3) |-> sr_rd_data[NV_ACC]);

  assert_compare_keeps_others_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sr_wr_en) |=> ((sr_rd_data & KEEP) == ($past(sr_rd_data) & KEEP)));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !sr_wr_en) |=> $stable(sr_rd_data));

  assert_no_type_without_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> (trap_type == '0));

endmodule

// File: tb/test_fp_cmp_cc.sv
module test_fp_cmp_cc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dbl = 1'b0, sr_wr_en = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [31:0] sr_wr_data = '0;
  logic [31:0] sr_rd_data;
  logic        done, trap;
  logic [7:0]  trap_type;

  int total = 0, bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fp_cmp_cc i_fp_cmp_cc (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl),
    .op_a(op_a), .op_b(op_b), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .sr_rd_data(sr_rd_data), .done(done), .trap(trap), .trap_type(trap_type)
  );

  localparam int NV = 22;
  localparam logic [130:0] VEC [NV] = '{
    {1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 2'd1},
    {1'b0, 64'h0000_0000_4000_0000, 64'h0000_0000_3F80_0000, 2'd2},
    {1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, 2'd0},
    {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, 2'd0},
    {1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, 2'd0},
    {1'b0, 64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, 2'd1},
    {1'b0, 64'h0000_0000_BF80_0000, 64'h0000_0000_C000_0000, 2'd2},
    {1'b0, 64'h0000_0000_FF80_0000, 64'h0000_0000_7F80_0000, 2'd1},
    {1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F7F_FFFF, 2'd2},
    {1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F80_0000, 2'd0},
    {1'b0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, 2'd3},
    {1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_7F80_0001, 2'd3},
    {1'b0, 64'h0000_0000_FFC0_0000, 64'h0000_0000_0000_0000, 2'd3},
    {1'b0, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 2'd1},
    {1'b1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 2'd1},
    {1'b1, 64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 2'd1},
    {1'b1, 64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000, 2'd2},
    {1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 2'd0},
    {1'b1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 2'd2},
    {1'b1, 64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 2'd2},
    {1'b1, 64'h3FF0_0000_7FC0_0000, 64'h3FF0_0000_7FC0_0000, 2'd0},
    {1'b1, 64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 2'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sr_write(input logic [31:0] v);
    @(negedge clk);
    sr_wr_en = 1'b1;
    sr_wr_data = v;
    @(negedge clk);
    sr_wr_en = 1'b0;
  endtask

  task automatic compare(input logic d, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    dbl = d; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 sr", sr_rd_data, 32'h0);
    chk("R1 done", {31'b0, done}, 32'h0);
    chk("R1 trap", {31'b0, trap}, 32'h0);
    chk("R1 type", {24'b0, trap_type}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0] ef;
      ef = VEC[i][1:0];
      sr_write(32'h0);
      compare(VEC[i][130], VEC[i][129:66], VEC[i][65:2]);
      chk("R2 done", {31'b0, done}, 32'h1);
      chk("R3 R4 R5 R6 R9 fcc", {30'b0, sr_rd_data[11:10]}, {30'b0, ef});
      chk("R8 accrued", {31'b0, sr_rd_data[5]}, {31'b0, ef == 2'd3});
      chk("R8 no trap", {31'b0, trap}, 32'h0);
      @(negedge clk);
      chk("R2 done drop", {31'b0, done}, 32'h0);
    end

    sr_write(32'h0800_4000);
    compare(1'b0, 64'h7FC0_0000, 64'h3F80_0000);
    chk("R7 trap", {31'b0, trap}, 32'h1);
    chk("R7 type", {24'b0, trap_type}, 32'h08);
    chk("R7 sr", sr_rd_data, 32'h0800_4C00);
    @(negedge clk);
    chk("R7 single pulse", {31'b0, trap}, 32'h0);
    chk("R11 type idle", {24'b0, trap_type}, 32'h0);

    sr_write(32'h0);
    compare(1'b1, 64'h7FF8_0000_0000_0000, 64'h0);
    compare(1'b0, 64'h3F80_0000, 64'h4000_0000);
    chk("R8 sticky", sr_rd_data, 32'h0000_0420);

    sr_write(32'hF7FF_F3DF);
    compare(1'b1, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000);
    chk("R10 preserve", sr_rd_data, 32'hF7FF_FBDF);

    sr_write(32'h0);
    @(negedge clk);
    sr_wr_en = 1'b1; sr_wr_data = 32'h1234_5000;
    dbl = 1'b0; op_a = 64'h7FC0_0000; op_b = 64'h0; start = 1'b1;
    @(negedge clk);
    sr_wr_en = 1'b0; start = 1'b0;
    chk("R10 overlay", sr_rd_data, 32'h1234_5C20);
    chk("R10 overlay trap", {31'b0, trap}, 32'h0);

    repeat (3) @(negedge clk);
    chk("R10 idle hold", sr_rd_data, 32'h1234_5C20);
    chk("R2 idle done", {31'b0, done}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule